// File: doc/BRIEF.md
# Five-Level Two-Carrier PWM Gate Generator

This block drives the six main switches of one phase leg of a reduced-switch five-level inverter. It also drives the leg's return-path switch and the two switches of its spare auxiliary cell. Each clock, it compares a signed, sampled sinusoidal reference against two triangular carriers that it generates itself. The two carriers run at the same frequency: one fills the positive half of the signed range and the other fills the negative half. The two comparison results and the sign of the reference go through fixed boolean equations to give the switch commands. Together these commands produce the leg's five levels: +2Vdc, +Vdc, 0, -Vdc and -2Vdc.

A mode input selects the switch pattern. In normal operation the return-path switch conducts and the auxiliary cell is idle. After a switch fault, the fault-handling logic sets the mode input. The return path is then released and the auxiliary cell carries the current in the half-cycle that matches the reference polarity. The reference generator, dead-time insertion and power stage sit outside this block.

Top module: `pwm5_gate_gen`

## Requirements
- R1: While `rst_n` is low, all nine switch commands are 0, and they stay 0 until the first rising clock edge after `rst_n` goes high.
- R2: The carrier counter starts at 0 after reset and rises by one per clock up to TOP = CLK_HZ/(2*SW_HZ). It then falls by one per clock back to 0, so one carrier period is 2*TOP clocks. The upper carrier is FULL*cnt/TOP and the lower carrier is that value minus FULL, where FULL = 2^(REF_W-1)-1.
- R3: Comparison bit H is 1 when ref*TOP > FULL*cnt, that is, when the reference lies above the upper carrier. Comparison bit L is 1 when ref*TOP > FULL*cnt - FULL*TOP, that is, when the reference lies above the lower carrier.
- R4: Polarity bit P is 1 when the signed reference is zero or positive (sign bit clear) and 0 otherwise. `sw_u2` carries P.
- R5: The main commands are: sw_u1 = (~H&P)|~P, sw_u2 = P, sw_u3 = (~L&P)|(~H&~P)|(L&~P), sw_l1 = H&P, sw_l2 = H&~P, sw_l3 = L.
- R6: All commands reflect the `ref_in` and `recfg` values present at a rising clock edge. They appear just after that edge, or one edge later when OUT_REG=1, and they do not change between edges.
- R7: With `recfg`=0, `sw_ret` is 1 and both auxiliary commands are 0.
- R8: With `recfg`=1, `sw_ret` is 0, `sw_aux_hi` equals P and `sw_aux_lo` equals ~P. The six main commands are unaffected by the mode.
- R9: In a positive half-cycle `sw_u2`=1, `sw_l2`=0 and `sw_l1` = ~`sw_u1`. In a negative half-cycle `sw_u2`=0, `sw_u1`=1 and `sw_l1`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | REF_W | Signed sampled sinusoidal reference |
| recfg | input | 1 | 1 selects the reconfigured pattern with the auxiliary cell |
| sw_u1 | output | 1 | Upper group switch 1 command |
| sw_u2 | output | 1 | Upper group switch 2 command (polarity) |
| sw_u3 | output | 1 | Upper group switch 3 command |
| sw_l1 | output | 1 | Lower group switch 1 command |
| sw_l2 | output | 1 | Lower group switch 2 command |
| sw_l3 | output | 1 | Lower group switch 3 command |
| sw_ret | output | 1 | Return-path switch command |
| sw_aux_hi | output | 1 | Auxiliary cell positive-half switch command |
| sw_aux_lo | output | 1 | Auxiliary cell negative-half switch command |

## Verification
A mode change and a reference polarity reversal can land on the same clock edge. At that edge the return-path and auxiliary commands change at the same moment as `sw_u2` and the rest of the main pattern. The bench provokes this by driving `recfg` and a sign-flipped reference in one cycle, in both directions. It judges the next sample against its behavioural model, which must show the new mode and the new polarity together with no mixed cycle. The sweep phase also toggles the mode while the reference crosses zero, so the coincidence recurs under many carrier phases.

// File: rtl/pwm5_pkg.sv
package pwm5_pkg;

   // Registered decision bits for one clock
   typedef struct packed {
      logic hi;     // reference above upper carrier
      logic lo;     // reference above lower carrier
      logic pos;    // reference non-negative
      logic recfg;  // reconfigured pattern selected
   } cmp_bits_t;

   // Switch command vector, MSB first
   typedef struct packed {
      logic u1;
      logic u2;
      logic u3;
      logic l1;
      logic l2;
      logic l3;
      logic ret;
      logic aux_hi;
      logic aux_lo;
   } gate_vec_t;

   localparam int GATE_N = $bits(gate_vec_t);

endpackage

// File: rtl/pwm5_carrier.sv
// Up/down triangle counter: 0 -> TOP -> 0, period 2*TOP clocks.
module pwm5_carrier #(
   parameter int TOP   = 100,
   parameter int CNT_W = $clog2(TOP + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] cnt
);

   localparam logic [CNT_W-1:0] TOP_C = CNT_W'(TOP);

   logic rising;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         rising <= 1'b1;
      end else if (rising) begin
         if (cnt == TOP_C) begin
            rising <= 1'b0;
            cnt    <= cnt - 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end else begin
         if (cnt == '0) begin
            rising <= 1'b1;
            cnt    <= cnt + 1'b1;
         end else begin
            cnt <= cnt - 1'b1;
         end
      end
   end

endmodule

// File: rtl/pwm5_compare.sv
// Compares the reference against both carriers by cross-multiplication
// and registers the decision bits once per clock.
module pwm5_compare
   import pwm5_pkg::*;
#(
   parameter int REF_W = 12,
   parameter int TOP   = 100,
   parameter int CNT_W = $clog2(TOP + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic signed [REF_W-1:0] ref_in,
   input  logic [CNT_W-1:0]        cnt,
   input  logic                    recfg,
   output cmp_bits_t               bits_q,
   output logic                    run_q
);

   localparam int PW   = REF_W + CNT_W + 2;
   localparam int FULL = (1 << (REF_W - 1)) - 1;

   localparam logic signed [PW-1:0] TOP_S  = PW'(TOP);
   localparam logic signed [PW-1:0] FULL_S = PW'(FULL);
   localparam logic signed [PW-1:0] SPAN_S = PW'(FULL * TOP);

   logic signed [PW-1:0] ref_s;
   logic signed [PW-1:0] cnt_s;
   logic signed [PW-1:0] ref_scaled;
   logic signed [PW-1:0] car_up;
   logic signed [PW-1:0] car_dn;
   cmp_bits_t            bits_d;

   always_comb begin
      ref_s       = $signed({{(PW-REF_W){ref_in[REF_W-1]}}, ref_in});
      cnt_s       = $signed({{(PW-CNT_W){1'b0}}, cnt});
      ref_scaled  = ref_s * TOP_S;
      car_up      = cnt_s * FULL_S;
      car_dn      = car_up - SPAN_S;
      bits_d.hi    = (ref_scaled > car_up);
      bits_d.lo    = (ref_scaled > car_dn);
      bits_d.pos   = ~ref_in[REF_W-1];
      bits_d.recfg = recfg;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bits_q <= '0;
         run_q  <= 1'b0;
      end else begin
         bits_q <= bits_d;
         run_q  <= 1'b1;
      end
   end

endmodule

// File: rtl/pwm5_gate_map.sv
// Boolean mapping from decision bits to switch commands.
module pwm5_gate_map
   import pwm5_pkg::*;
(
   input  cmp_bits_t bits,
   output gate_vec_t gates
);

   logic h, l, p, m;

   always_comb begin
      h = bits.hi;
      l = bits.lo;
      p = bits.pos;
      m = bits.recfg;
      gates.u1     = (~h & p) | ~p;
      gates.u2     = p;
      gates.u3     = (~l & p) | (~h & ~p) | (l & ~p);
      gates.l1     = h & p;
      gates.l2     = h & ~p;
      gates.l3     = l;
      gates.ret    = ~m;
      gates.aux_hi = m & p;
      gates.aux_lo = m & ~p;
   end

endmodule

// File: rtl/pwm5_gate_gen.sv
module pwm5_gate_gen
   import pwm5_pkg::*;
#(
   parameter int REF_W   = 12,
   parameter int CLK_HZ  = 100_000_000,
   parameter int SW_HZ   = 3050,
   parameter bit OUT_REG = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic signed [REF_W-1:0] ref_in,
   input  logic                    recfg,
   output logic                    sw_u1,
   output logic                    sw_u2,
   output logic                    sw_u3,
   output logic                    sw_l1,
   output logic                    sw_l2,
   output logic                    sw_l3,
   output logic                    sw_ret,
   output logic                    sw_aux_hi,
   output logic                    sw_aux_lo
);

   localparam int TOP   = CLK_HZ / (2 * SW_HZ);
   localparam int CNT_W = $clog2(TOP + 1);

   // Elaboration-time parameter checks
   if (REF_W < 4 || REF_W > 16) begin : g_bad_ref_w
      $error("pwm5_gate_gen: REF_W must be within 4..16");
   end
   if (TOP < 2) begin : g_bad_top
      $error("pwm5_gate_gen: CLK_HZ too low for SW_HZ");
   end
   if (CNT_W > 24) begin : g_bad_cnt
      $error("pwm5_gate_gen: carrier counter too wide");
   end

   logic [CNT_W-1:0] cnt;
   cmp_bits_t        bits_q;
   logic             run_q;
   gate_vec_t        gates_raw;
   gate_vec_t        gates_live;
   gate_vec_t        gates_out;

   pwm5_carrier #(.TOP(TOP), .CNT_W(CNT_W)) u_carrier (
      .clk   (clk),
      .rst_n (rst_n),
      .cnt   (cnt)
   );

   pwm5_compare #(.REF_W(REF_W), .TOP(TOP), .CNT_W(CNT_W)) u_compare (
      .clk    (clk),
      .rst_n  (rst_n),
      .ref_in (ref_in),
      .cnt    (cnt),
      .recfg  (recfg),
      .bits_q (bits_q),
      .run_q  (run_q)
   );

   pwm5_gate_map u_map (
      .bits  (bits_q),
      .gates (gates_raw)
   );

   // Hold every command low until the first decision after reset
   assign gates_live = run_q ? gates_raw : '0;

   if (OUT_REG) begin : g_out_reg
      gate_vec_t gates_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) gates_q <= '0;
         else        gates_q <= gates_live;
      end
      assign gates_out = gates_q;
   end else begin : g_out_comb
      assign gates_out = gates_live;
   end

   assign sw_u1     = gates_out.u1;
   assign sw_u2     = gates_out.u2;
   assign sw_u3     = gates_out.u3;
   assign sw_l1     = gates_out.l1;
   assign sw_l2     = gates_out.l2;
   assign sw_l3     = gates_out.l3;
   assign sw_ret    = gates_out.ret;
   assign sw_aux_hi = gates_out.aux_hi;
   assign sw_aux_lo = gates_out.aux_lo;

endmodule

// File: rtl/pwm5_gate_chk.sv
module pwm5_gate_chk #(
   parameter int REF_W   = 12,
   parameter bit OUT_REG = 1'b0
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic signed [REF_W-1:0] ref_in,
   input logic                    recfg,
   input logic                    sw_u1,
   input logic                    sw_u2,
   input logic                    sw_u3,
   input logic                    sw_l1,
   input logic                    sw_l2,
   input logic                    sw_l3,
   input logic                    sw_ret,
   input logic                    sw_aux_hi,
   input logic                    sw_aux_lo
);

   // R1: quiet outputs during reset
   always @(negedge clk) begin
      if (!rst_n) begin
         p_reset_quiet_r1: assert ({sw_u1, sw_u2, sw_u3, sw_l1, sw_l2, sw_l3,
                                    sw_ret, sw_aux_hi, sw_aux_lo} == 9'd0)
            else $error("switch command active during reset");
      end
   end

   // R9: half-cycle pairing among the main commands (no input delay needed)
   p_halfcycle_pairs_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (sw_u2 ? (!sw_l2 && (sw_l1 != sw_u1)) : (sw_u1 && !sw_l1)));

   if (OUT_REG) begin : g_lat2
      p_healthy_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (rst_n && !recfg) |=> ##1 (sw_ret && !sw_aux_hi && !sw_aux_lo));
      p_reconfig_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (rst_n && recfg) |=> ##1 (!sw_ret && (sw_aux_hi == sw_u2) && (sw_aux_lo == !sw_u2)));
      p_polarity_r4: assert property (@(posedge clk) disable iff (!rst_n)
         rst_n |=> ##1 (sw_u2 == !$past(ref_in[REF_W-1], 2)));
   end else begin : g_lat1
      p_healthy_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (rst_n && !recfg) |=> (sw_ret && !sw_aux_hi && !sw_aux_lo));
      p_reconfig_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (rst_n && recfg) |=> (!sw_ret && (sw_aux_hi == sw_u2) && (sw_aux_lo == !sw_u2)));
      p_polarity_r4: assert property (@(posedge clk) disable iff (!rst_n)
         rst_n |=> (sw_u2 == !$past(ref_in[REF_W-1])));
   end

endmodule

bind pwm5_gate_gen pwm5_gate_chk #(.REF_W(REF_W), .OUT_REG(OUT_REG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ref_in    (ref_in),
   .recfg     (recfg),
   .sw_u1     (sw_u1),
   .sw_u2     (sw_u2),
   .sw_u3     (sw_u3),
   .sw_l1     (sw_l1),
   .sw_l2     (sw_l2),
   .sw_l3     (sw_l3),
   .sw_ret    (sw_ret),
   .sw_aux_hi (sw_aux_hi),
   .sw_aux_lo (sw_aux_lo)
);

// File: tb/tb_pwm5_gate_gen.sv
module tb_pwm5_gate_gen;

   localparam int CLK_PERIOD = 10;
   localparam int REF_W      = 12;
   localparam int CLK_HZ     = 610_000;
   localparam int SW_HZ      = 3050;
   localparam bit OUT_REG    = 1'b0;
   localparam int TOP        = CLK_HZ / (2 * SW_HZ);
   localparam int FULL       = (1 << (REF_W - 1)) - 1;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic signed [REF_W-1:0] ref_in = '0;
   logic                    recfg = 1'b0;
   logic sw_u1, sw_u2, sw_u3, sw_l1, sw_l2, sw_l3, sw_ret, sw_aux_hi, sw_aux_lo;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   pwm5_gate_gen #(.REF_W(REF_W), .CLK_HZ(CLK_HZ), .SW_HZ(SW_HZ), .OUT_REG(OUT_REG)) dut (
      .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .recfg(recfg),
      .sw_u1(sw_u1), .sw_u2(sw_u2), .sw_u3(sw_u3),
      .sw_l1(sw_l1), .sw_l2(sw_l2), .sw_l3(sw_l3),
      .sw_ret(sw_ret), .sw_aux_hi(sw_aux_hi), .sw_aux_lo(sw_aux_lo)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [8:0] outs();
      return {sw_u1, sw_u2, sw_u3, sw_l1, sw_l2, sw_l3, sw_ret, sw_aux_hi, sw_aux_lo};
   endfunction

   task automatic chk(string tag, string what, longint act, longint exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // Behavioural reference from the requirements (R2, R3, R4, R5, R7, R8)
   function automatic logic [8:0] model_vec(int r, int c, bit m);
      longint lhs = longint'(r) * TOP;
      longint up  = longint'(c) * FULL;
      bit h = (lhs > up);
      bit l = (lhs > up - longint'(FULL) * TOP);
      bit p = (r >= 0);
      logic [8:0] v;
      v[8] = (!h && p) || !p;
      v[7] = p;
      v[6] = (!l && p) || (!h && !p) || (l && !p);
      v[5] = h && p;
      v[4] = h && !p;
      v[3] = l;
      v[2] = !m;
      v[1] = m && p;
      v[0] = m && !p;
      return v;
   endfunction

   int         m_cnt = 0;
   bit         m_up  = 1'b1;
   logic [8:0] expq[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0;
         m_up  = 1'b1;
         expq.delete();
      end else begin
         expq.push_back(model_vec(int'(ref_in), m_cnt, recfg));
         if (m_up) begin
            if (m_cnt == TOP) begin m_up = 1'b0; m_cnt = m_cnt - 1; end
            else m_cnt = m_cnt + 1;
         end else begin
            if (m_cnt == 0) begin m_up = 1'b1; m_cnt = m_cnt + 1; end
            else m_cnt = m_cnt - 1;
         end
      end
   end

   function automatic string out_name(int i);
      case (i)
         8: return "sw_u1";  7: return "sw_u2";  6: return "sw_u3";
         5: return "sw_l1";  4: return "sw_l2";  3: return "sw_l3";
         2: return "sw_ret"; 1: return "sw_aux_hi";
         default: return "sw_aux_lo";
      endcase
   endfunction

   // Per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n && expq.size() > int'(OUT_REG)) begin
         logic [8:0] e;
         logic [8:0] g;
         e = expq.pop_front();
         g = outs();
         for (int i = 0; i < 9; i++) begin
            if (i >= 3) chk("R3/R5", out_name(i), g[i], e[i]);
            else        chk("R7/R8", out_name(i), g[i], e[i]);
         end
         // R9 half-cycle pairing
         if (g[7]) chk("R9", "pos half sw_l2|sw_l1==sw_u1", {g[4], g[5] == g[8]}, 2'b00);
         else      chk("R9", "neg half sw_u1,sw_l1", {g[8], g[5]}, 2'b10);
      end
   end

   task automatic step(int r, bit m);
      @(negedge clk);
      ref_in = REF_W'(r);
      recfg  = m;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int rises[$];
      int cyc;
      logic prev;

      // R1: reset state
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk("R1", "outputs in reset", outs(), 0);
      end
      rst_n = 1'b1;

      // R2: carrier period seen on sw_l1 rising edges with a fixed reference
      ref_in = REF_W'(1023);
      recfg  = 1'b0;
      prev   = 1'b0;
      cyc    = 0;
      for (int i = 0; i < 5 * TOP; i++) begin
         @(negedge clk);
         cyc++;
         if (sw_l1 && !prev) rises.push_back(cyc);
         prev = sw_l1;
      end
      chk("R2", "rising edges seen >= 2", rises.size() >= 2, 1);
      if (rises.size() >= 2)
         chk("R2", "carrier period in clocks",
             rises[rises.size()-1] - rises[rises.size()-2], 2 * TOP);

      // R6: polarity change is invisible until the next edge
      if (!OUT_REG) begin
         @(negedge clk);
         ref_in = REF_W'(-500);
         #(CLK_PERIOD/4);
         chk("R6", "sw_u2 before edge", sw_u2, 1);
         @(negedge clk);
         chk("R6", "sw_u2 after edge", sw_u2, 0);
      end

      // Sweep through both polarities, mode toggling during the sweep
      for (int k = 0; k < 800; k++)
         step(-FULL + ((k * 53) % (2 * FULL + 1)), k[6]);

      // Mode change and polarity reversal on the same edge (R8, R7, R4)
      step(700, 1'b0);
      step(700, 1'b0);
      step(-700, 1'b1);
      if (!OUT_REG) begin
         @(negedge clk);
         chk("R8", "sw_ret off in reconfig", sw_ret, 0);
         chk("R8", "sw_aux_lo on in negative half", sw_aux_lo, 1);
         chk("R4", "sw_u2 negative half", sw_u2, 0);
         ref_in = REF_W'(5);
         recfg  = 1'b0;
         @(negedge clk);
         chk("R7", "sw_ret on in healthy", sw_ret, 1);
         chk("R7", "sw_aux_hi off in healthy", sw_aux_hi, 0);
         chk("R4", "sw_u2 positive half", sw_u2, 1);
      end

      // Boundary references: full scale, most negative code, zero, minus one
      for (int i = 0; i < 2 * TOP; i++) step(FULL, 1'b1);
      for (int i = 0; i < 2 * TOP; i++) step(-FULL - 1, 1'b0);
      for (int i = 0; i < 2 * TOP; i++) step(0, 1'b1);
      for (int i = 0; i < 2 * TOP; i++) step(-1, 1'b1);

      // Random references and modes
      for (int i = 0; i < 1500; i++)
         step(int'($urandom_range(0, 2 * FULL)) - FULL, 1'($urandom_range(0, 1)));

      // R1: reset applied in mid-run
      @(negedge clk);
      #(CLK_PERIOD/4);
      rst_n = 1'b0;
      #1;
      chk("R1", "outputs right after mid-run reset", outs(), 0);
      @(negedge clk);
      chk("R1", "outputs held in reset", outs(), 0);
      rst_n = 1'b1;
      for (int i = 0; i < 60; i++)
         step(int'($urandom_range(0, 2 * FULL)) - FULL, 1'($urandom_range(0, 1)));

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule